// File: doc/BRIEF.md
# Transmit Robbed-Bit Signaling Inserter

This block sits on the transmit backplane path of a T1 framer, working in the bit-clock domain at one serial bit per clock. It takes the outgoing PCM stream and a parallel serial signaling stream that is aligned to it. In the signaling frames of the multiframe, it writes the per-channel A/B/C/D signaling bit into the least significant bit of each channel. Both D4 (12-frame) and ESF (24-frame) multiframes are supported. The frame sync and multiframe sync inputs give the alignment. Between syncs, an internal position counter free-runs.

Insertion has a global enable. When the per-channel option is set, a channel is excluded by holding the block strobe high during that channel. The block behaves the same whether or not a transmit elastic store is upstream, because it only relies on the serial stream and its syncs. The output is registered and has a fixed latency of one clock. Reset is synchronous and active high.

Top module: `tx_sig_insert`

## Requirements
- R1: While `rst` is high at a clock edge, `serOut` is 0 after that edge.
- R2: Every bit that is not a signaling position appears on `serOut` unchanged, exactly one clock after it is presented on `serIn`.
- R3: The framing bit (the cycle in which `frameSync` is high, or the cycle after the last bit of the last channel) is never altered.
- R4: With `sigEnable` low, `serOut` equals `serIn` delayed by one clock in every position.
- R5: In D4 mode (`esfMode`=0), in frames 6 and 12 the last (8th) bit of every channel is replaced by signaling bit A and bit B respectively. Frame 1 is the frame whose framing bit coincides with `mfSync` high.
- R6: In ESF mode (`esfMode`=1), in frames 6, 12, 18 and 24 the last bit of every channel is replaced by A, B, C and D respectively.
- R7: A, B, C and D are taken from the first, second, third and fourth bit of `sigIn` within the same channel slot of the same frame. The remaining `sigIn` bits of the slot and the framing-bit cycle are ignored.
- R8: With `perChanEn` high, a channel for which `blockIn` is high during its last bit keeps its original bit.
- R9: With `perChanEn` low, `blockIn` has no effect and every channel receives signaling.
- R10: After reset, no bit is replaced until `frameSync` and `mfSync` have been high together once.
- R11: Once aligned, the bit, channel and frame positions advance on their own, so insertion continues correctly when `frameSync` and `mfSync` are absent for whole frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| esfMode | input | 1 | 1 selects the 24-frame multiframe, 0 selects the 12-frame multiframe |
| sigEnable | input | 1 | Enables signaling insertion |
| perChanEn | input | 1 | Lets `blockIn` exclude individual channels |
| frameSync | input | 1 | High during the framing-bit cycle |
| mfSync | input | 1 | High with `frameSync` on frame 1 of a multiframe |
| blockIn | input | 1 | Per-channel exclusion strobe, held through the channel |
| serIn | input | 1 | Serial PCM data in |
| sigIn | input | 1 | Serial signaling data in, ABCD in the first four bits of each channel slot |
| serOut | output | 1 | Serial PCM data out with signaling inserted |

## Verification
The bench builds the block with `CHANNELS` set to 4 and `CH_BITS` left at 8, which gives a 33-bit frame. At that size a full ESF multiframe takes 792 clocks. This keeps every signaling frame, every ABCD position, multiframe wrap in both modes, and a free-running stretch without syncs within a short run. The block strobe mask on four channels lets the blocked and unblocked cases be compared inside the same frame.

// File: rtl/txsig_pkg.sv
package txsig_pkg;
  localparam int SIG_BITS   = 4;   // A, B, C, D
  localparam int SIG_PERIOD = 6;   // one signaling frame every sixth frame
  localparam int D4_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;

  typedef struct packed {
    logic       fBit;      // current cycle is the framing bit
    logic       capValid;  // current sigIn bit is one of A..D
    logic [1:0] capIdx;    // which of A..D it is
    logic       lsbSlot;   // current cycle is a channel LSB in a signaling frame
    logic       insert;    // replace this bit with signaling
    logic [1:0] sigSel;    // which of A..D to insert
  } ctrlStb_t;
endpackage

// File: rtl/txsig_ctrl.sv
module txsig_ctrl
  import txsig_pkg::*;
#(
  parameter int CHANNELS = 24,
  parameter int CH_BITS  = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     esfMode,
  input  logic     sigEnable,
  input  logic     perChanEn,
  input  logic     frameSync,
  input  logic     mfSync,
  input  logic     blockIn,
  output ctrlStb_t stb
);
  localparam int CH_W  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam int BIT_W = $clog2(CH_BITS);
  localparam int FR_W  = $clog2(ESF_FRAMES);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CH_BITS - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CHANNELS - 1);
  localparam logic [FR_W-1:0]  D4_LAST  = FR_W'(D4_FRAMES - 1);
  localparam logic [FR_W-1:0]  ESF_LAST = FR_W'(ESF_FRAMES - 1);
  localparam int MAX_SIG = ESF_FRAMES / SIG_PERIOD;

  logic             prevF, curF;
  logic [BIT_W-1:0] prevBit, curBit;
  logic [CH_W-1:0]  prevChan, curChan;
  logic [FR_W-1:0]  prevFrame, curFrame, lastFrame;
  logic             syncedQ, curSynced;
  logic             sigFrame;
  logic [1:0]       sigSel;

  assign lastFrame = esfMode ? ESF_LAST : D4_LAST;

  // position within the frame: framing bit, then channels of CH_BITS bits
  always_comb begin
    curF    = 1'b0;
    curBit  = prevBit;
    curChan = prevChan;
    if (frameSync) begin
      curF = 1'b1;
    end else if (prevF) begin
      curBit  = '0;
      curChan = '0;
    end else if (prevBit == BIT_LAST) begin
      curBit = '0;
      if (prevChan == CH_LAST) curF = 1'b1;
      else                     curChan = prevChan + 1'b1;
    end else begin
      curBit = prevBit + 1'b1;
    end
  end

  // frame number within the multiframe, advanced on each framing bit
  always_comb begin
    curFrame = prevFrame;
    if (curF) begin
      if (frameSync && mfSync)        curFrame = '0;
      else if (prevFrame >= lastFrame) curFrame = '0;
      else                            curFrame = prevFrame + 1'b1;
    end
  end

  assign curSynced = syncedQ | (frameSync & mfSync);

  // signaling frames: every SIG_PERIOD-th frame, two per D4, four per ESF
  always_comb begin
    sigFrame = 1'b0;
    sigSel   = 2'd0;
    for (int k = 0; k < MAX_SIG; k++) begin
      if (curFrame == FR_W'(k * SIG_PERIOD + SIG_PERIOD - 1) &&
          (esfMode || k < D4_FRAMES / SIG_PERIOD)) begin
        sigFrame = 1'b1;
        sigSel   = 2'(k);
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.fBit     = curF;
    stb.capValid = !curF && (curBit < BIT_W'(SIG_BITS));
    stb.capIdx   = curBit[1:0];
    stb.lsbSlot  = !curF && (curBit == BIT_LAST) && sigFrame;
    stb.sigSel   = sigSel;
    stb.insert   = stb.lsbSlot && sigEnable && curSynced &&
                   !(perChanEn && blockIn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevF     <= 1'b0;
      prevBit   <= BIT_LAST;
      prevChan  <= CH_LAST;
      prevFrame <= '0;
      syncedQ   <= 1'b0;
    end else begin
      prevF     <= curF;
      prevBit   <= curBit;
      prevChan  <= curChan;
      prevFrame <= curFrame;
      syncedQ   <= curSynced;
    end
  end

  // R10
  no_early_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (!syncedQ && !(frameSync && mfSync)) |-> !stb.insert);
endmodule

// File: rtl/txsig_datapath.sv
module txsig_datapath
  import txsig_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ctrlStb_t stb,
  input  logic     serIn,
  input  logic     sigIn,
  output logic     serOut
);
  logic [SIG_BITS-1:0] nibble;

  always_ff @(posedge clk) begin
    if (rst) begin
      nibble <= '0;
      serOut <= 1'b0;
    end else begin
      if (stb.capValid) nibble[stb.capIdx] <= sigIn;
      serOut <= stb.insert ? nibble[stb.sigSel] : serIn;
    end
  end

  // R7
  slot_class_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.fBit, stb.capValid, stb.lsbSlot}));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.insert |=> serOut == $past(serIn));

  // R3
  fbit_keep_chk: assert property (@(posedge clk) disable iff (rst)
    stb.fBit |=> serOut == $past(serIn));
endmodule

// File: rtl/tx_sig_insert.sv
module tx_sig_insert
  import txsig_pkg::*;
#(
  parameter int CHANNELS = 24,
  parameter int CH_BITS  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic esfMode,
  input  logic sigEnable,
  input  logic perChanEn,
  input  logic frameSync,
  input  logic mfSync,
  input  logic blockIn,
  input  logic serIn,
  input  logic sigIn,
  output logic serOut
);
  ctrlStb_t stb;

  txsig_ctrl #(.CHANNELS(CHANNELS), .CH_BITS(CH_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .esfMode(esfMode), .sigEnable(sigEnable),
    .perChanEn(perChanEn), .frameSync(frameSync), .mfSync(mfSync),
    .blockIn(blockIn), .stb(stb)
  );

  txsig_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .serIn(serIn), .sigIn(sigIn),
    .serOut(serOut)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> !serOut);

  // R4
  disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !sigEnable |=> serOut == $past(serIn));

  // R8
  blocked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (perChanEn && blockIn) |=> serOut == $past(serIn));

  // R3
  sync_fbit_chk: assert property (@(posedge clk) disable iff (rst)
    frameSync |=> serOut == $past(serIn));
endmodule

// File: tb/tx_sig_insert_test.sv
module tx_sig_insert_test;
  localparam int CH  = 4;
  localparam int CHB = 8;
  localparam int FRAME_BITS = 1 + CH * CHB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic esfMode = 1'b0, sigEnable = 1'b0, perChanEn = 1'b0;
  logic frameSync = 1'b0, mfSync = 1'b0, blockIn = 1'b0;
  logic serIn = 1'b0, sigIn = 1'b0;
  logic serOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit benchSynced = 1'b0;
  bit prevValid = 1'b0;
  logic prevExp = 1'b0;
  string prevTag = "";

  always #10 clk = ~clk;

  tx_sig_insert #(.CHANNELS(CH), .CH_BITS(CHB)) uut (
    .clk(clk), .rst(rst), .esfMode(esfMode), .sigEnable(sigEnable),
    .perChanEn(perChanEn), .frameSync(frameSync), .mfSync(mfSync),
    .blockIn(blockIn), .serIn(serIn), .sigIn(sigIn), .serOut(serOut)
  );

  task automatic checkBit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: serOut=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare the output for the bit driven one cycle earlier
  task automatic comparePrev();
    if (prevValid) checkBit(serOut, prevExp, prevTag);
  endtask

  function automatic logic pcmBit(int f, int c, int b, int seed);
    return ((f * 7 + c * 13 + b * 5 + seed) % 11) < 5;
  endfunction

  function automatic logic [3:0] nibOf(int f, int c, int seed);
    return 4'((c * 5 + f * 3 + seed) & 15);
  endfunction

  task automatic runFrames(input int nFrames, input bit esf, input bit en,
                           input bit pc, input logic [CH-1:0] mask,
                           input int seed, input bit syncAll, input bit mfOn,
                           input string tag);
    int fpm;
    fpm = esf ? 24 : 12;
    for (int fr = 0; fr < nFrames; fr++) begin
      int f;
      f = fr % fpm;
      for (int p = 0; p < FRAME_BITS; p++) begin
        @(negedge clk);
        comparePrev();
        esfMode   = esf;
        sigEnable = en;
        perChanEn = pc;
        if (p == 0) begin
          frameSync = syncAll || (fr == 0);
          mfSync    = frameSync && mfOn && (f == 0);
          if (mfSync) benchSynced = 1'b1;
          serIn   = 1'((fr + seed) & 1);
          sigIn   = ~serIn;
          blockIn = 1'b0;
          prevExp = serIn;
          prevTag = "R3";
        end else begin
          int c, b;
          logic [3:0] nib;
          c = (p - 1) / CHB;
          b = (p - 1) % CHB;
          nib = nibOf(f, c, seed);
          frameSync = 1'b0;
          mfSync    = 1'b0;
          serIn   = pcmBit(f, c, b, seed);
          sigIn   = (b < 4) ? nib[b] : ~serIn;
          blockIn = mask[c];
          prevExp = serIn;
          prevTag = "R2";
          if (b == CHB - 1 && (f % 6) == 5) begin
            prevTag = tag;
            if (benchSynced && en && !(pc && mask[c])) prevExp = nib[f / 6];
          end
        end
        prevValid = 1'b1;
      end
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checkBit(serOut, 1'b0, "R1");
    rst = 1'b0;
  endtask

  task automatic testNoAlign();   // R10
    runFrames(14, 1'b1, 1'b1, 1'b0, '0, 3, 1'b1, 1'b0, "R10");
  endtask

  task automatic testDisabled();  // R4
    runFrames(24, 1'b1, 1'b0, 1'b0, '0, 1, 1'b1, 1'b1, "R4");
  endtask

  task automatic testD4();        // R5, R7
    runFrames(24, 1'b0, 1'b1, 1'b0, '0, 2, 1'b1, 1'b1, "R5 R7");
  endtask

  task automatic testEsf();       // R6, R7
    runFrames(24, 1'b1, 1'b1, 1'b0, '0, 5, 1'b1, 1'b1, "R6 R7");
  endtask

  task automatic testPerChan();   // R8
    runFrames(24, 1'b1, 1'b1, 1'b1, 4'b0101, 7, 1'b1, 1'b1, "R8");
    runFrames(12, 1'b0, 1'b1, 1'b1, 4'b1010, 8, 1'b1, 1'b1, "R8");
  endtask

  task automatic testMaskIgnored(); // R9
    runFrames(12, 1'b0, 1'b1, 1'b0, 4'b1111, 9, 1'b1, 1'b1, "R9");
  endtask

  task automatic testFlywheel();  // R11
    runFrames(48, 1'b1, 1'b1, 1'b0, '0, 4, 1'b0, 1'b1, "R11");
    runFrames(24, 1'b0, 1'b1, 1'b0, '0, 6, 1'b0, 1'b1, "R11");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testNoAlign();
    testDisabled();
    testD4();
    testEsf();
    testPerChan();
    testMaskIgnored();
    testFlywheel();
    @(negedge clk);
    comparePrev();
    prevValid = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule